// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Front End

This block is the digital side of a two-channel voltage-output converter. A host sends a data word serially, most significant bit first, on a data pin clocked by a serial clock, with an active-low enable that gates the shifting. Two active-low, level-sensitive load strobes then copy the shift register into the channel A or channel B word. These words drive the converters, which sit outside this block.

An active-low preset input forces both channel words to zero or to midscale, chosen by a static select pin. An active-low sleep input only sets a status flag and never touches stored data. The block runs on a fast system clock. Every pin is first passed through a two-flop synchronizer, and a serial clock edge is found as a low-to-high step of its synchronized copy. The resolution `WIDTH` is 10 or 12 bits.

Top module: `dual_dac_regs`

## Requirements
- R1: On each rising serial clock edge while `ser_en_ni` is low, the shift register moves one place towards its most significant bit and takes `ser_data_i` into bit 0. The first bit sent therefore ends up as the word's MSB.
- R2: While `ser_en_ni` is high, serial clock edges leave the shift register unchanged.
- R3: When a frame has more than `WIDTH` clocks (for example 16), only the last `WIDTH` bits received are kept. A frame of exactly `WIDTH` clocks fills the register completely.
- R4: While `load_a_ni` is low, `word_a_o` follows the shift register, including bits shifted in during the strobe. After the strobe rises, `word_a_o` holds its value while new frames are shifted in.
- R5: `load_b_ni` loads `word_b_o` in the same way. A strobe on one channel leaves the other channel's word unchanged.
- R6: Driving both strobes low together loads the same shift register value into both words.
- R7: The load strobes work whatever the level of `ser_en_ni`, including while it is high.
- R8: While `preset_ni` is low and `preset_mid_i` is low, both words read all zeros.
- R9: While `preset_ni` is low and `preset_mid_i` is high, both words read midscale: MSB set, all other bits zero (0x800 for 12 bits, 0x200 for 10 bits).
- R10: The preset takes priority over the load strobes. With both active, the words take the preset value.
- R11: `sleep_o` is high while `sleep_ni` is low. Sleep changes neither the shift register nor the words, and shifting and loading still work during sleep.
- R12: After the system reset `rst_ni`, both words are zero and `sleep_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all pins |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| ser_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_en_ni | input | 1 | Active-low shift enable |
| load_a_ni | input | 1 | Active-low level load strobe for channel A |
| load_b_ni | input | 1 | Active-low level load strobe for channel B |
| preset_ni | input | 1 | Active-low preset of both channel words |
| preset_mid_i | input | 1 | Preset target select: 1 gives midscale, 0 gives zero |
| sleep_ni | input | 1 | Active-low sleep request |
| word_a_o | output | WIDTH | Channel A register word |
| word_b_o | output | WIDTH | Channel B register word |
| sleep_o | output | 1 | High while sleep is requested |

## Verification
The bench builds two copies of the block, one with `WIDTH` 12 and one with `WIDTH` 10, and drives both from the same pins. This lets one 16-clock frame show both truncation lengths at once. A 10-clock frame leaves stale upper bits in the 12-bit copy, while a 12-clock frame overflows the 10-bit copy. Midscale is also checked at two different bit positions.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned CHAN_N     = 2;
  localparam int unsigned PIN_N      = 8;
  localparam int unsigned P_SCK  = 0;
  localparam int unsigned P_SDAT = 1;
  localparam int unsigned P_EN   = 2;
  localparam int unsigned P_LDA  = 3;
  localparam int unsigned P_LDB  = 4;
  localparam int unsigned P_PRE  = 5;
  localparam int unsigned P_MID  = 6;
  localparam int unsigned P_SLP  = 7;
  // idle level of each pin, used as synchronizer reset value
  localparam logic [PIN_N-1:0] PIN_IDLE = 8'b1011_1100;
endpackage

// File: rtl/dd_pin_sync.sv
module dd_pin_sync #(
  parameter int unsigned            WIDTH   = 8,
  parameter int unsigned            STAGES  = 2,
  parameter logic [WIDTH-1:0]       RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q[0] <= din_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign dout_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dd_shift.sv
module dd_shift #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             sdat_i,
  input  logic             en_i,
  output logic             go_o,
  output logic [WIDTH-1:0] shift_o
);
  logic             sck_q;
  logic [WIDTH-1:0] shift_q;

  assign go_o = en_i & sck_i & ~sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      shift_q <= '0;
    end else begin
      sck_q <= sck_i;
      // older bits fall off the top: last WIDTH bits survive
      if (go_o) shift_q <= {shift_q[WIDTH-2:0], sdat_i};
    end
  end

  assign shift_o = shift_q;
endmodule

// File: rtl/dd_chan.sv
module dd_chan #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             preset_i,
  input  logic             mid_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] word_o
);
  localparam logic [WIDTH-1:0] MID_WORD = {1'b1, {(WIDTH-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       word_o <= '0;
    else if (preset_i) word_o <= mid_i ? MID_WORD : '0;
    else if (load_i)   word_o <= din_i;
  end
endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
  import dual_dac_pkg::*;
#(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_clk_i,
  input  logic             ser_data_i,
  input  logic             ser_en_ni,
  input  logic             load_a_ni,
  input  logic             load_b_ni,
  input  logic             preset_ni,
  input  logic             preset_mid_i,
  input  logic             sleep_ni,
  output logic [WIDTH-1:0] word_a_o,
  output logic [WIDTH-1:0] word_b_o,
  output logic             sleep_o
);
  logic [PIN_N-1:0]             pins_raw, pins_s;
  logic                         shift_go, pre_act, pre_mid;
  logic [CHAN_N-1:0]            ld_vec;
  logic [WIDTH-1:0]             shift_q;
  logic [CHAN_N-1:0][WIDTH-1:0] words;

  always_comb begin
    pins_raw         = '0;
    pins_raw[P_SCK]  = ser_clk_i;
    pins_raw[P_SDAT] = ser_data_i;
    pins_raw[P_EN]   = ser_en_ni;
    pins_raw[P_LDA]  = load_a_ni;
    pins_raw[P_LDB]  = load_b_ni;
    pins_raw[P_PRE]  = preset_ni;
    pins_raw[P_MID]  = preset_mid_i;
    pins_raw[P_SLP]  = sleep_ni;
  end

  dd_pin_sync #(.WIDTH(PIN_N), .STAGES(SYNC_DEPTH), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (pins_raw),
    .dout_o(pins_s)
  );

  assign pre_act   = ~pins_s[P_PRE];
  assign pre_mid   = pins_s[P_MID];
  assign ld_vec[0] = ~pins_s[P_LDA];
  assign ld_vec[1] = ~pins_s[P_LDB];

  dd_shift #(.WIDTH(WIDTH)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (pins_s[P_SCK]),
    .sdat_i (pins_s[P_SDAT]),
    .en_i   (~pins_s[P_EN]),
    .go_o   (shift_go),
    .shift_o(shift_q)
  );

  for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
    dd_chan #(.WIDTH(WIDTH)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (ld_vec[c]),
      .preset_i(pre_act),
      .mid_i   (pre_mid),
      .din_i   (shift_q),
      .word_o  (words[c])
    );
  end

  assign word_a_o = words[0];
  assign word_b_o = words[1];
  assign sleep_o  = ~pins_s[P_SLP];
endmodule

// File: rtl/dual_dac_regs_chk.sv
module dual_dac_regs_chk #(
  parameter int unsigned WIDTH = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shift_go,
  input logic             sdat_s,
  input logic [WIDTH-1:0] shift_q,
  input logic             pre_act,
  input logic             pre_mid,
  input logic [1:0]       ld_vec,
  input logic [WIDTH-1:0] word_a_o,
  input logic [WIDTH-1:0] word_b_o
);
  localparam logic [WIDTH-1:0] MID_WORD = {1'b1, {(WIDTH-1){1'b0}}};

  p_shift_in_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_go |=> shift_q == {$past(shift_q[WIDTH-2:0]), $past(sdat_s)});

  p_shift_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_go |=> $stable(shift_q));

  p_follow_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_vec[0] && !pre_act) |=> word_a_o == $past(shift_q));

  p_hold_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_vec[0] && !pre_act) |=> $stable(word_a_o));

  p_hold_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_vec[1] && !pre_act) |=> $stable(word_b_o));

  p_preset_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_act && !pre_mid) |=> (word_a_o == '0 && word_b_o == '0));

  p_preset_mid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_act && pre_mid) |=> (word_a_o == MID_WORD && word_b_o == MID_WORD));

  p_preset_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_act && pre_mid && ld_vec != 2'b00) |=> $onehot(word_a_o | word_b_o));
endmodule

bind dual_dac_regs dual_dac_regs_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .shift_go(shift_go),
  .sdat_s  (pins_s[dual_dac_pkg::P_SDAT]),
  .shift_q (shift_q),
  .pre_act (pre_act),
  .pre_mid (pre_mid),
  .ld_vec  (ld_vec),
  .word_a_o(word_a_o),
  .word_b_o(word_b_o)
);

// File: tb/tb_dual_dac_regs.sv
`timescale 1ns/1ps
module tb_dual_dac_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdat = 1'b0, en_n = 1'b1, lda_n = 1'b1, ldb_n = 1'b1;
  logic pre_n = 1'b1, mid = 1'b0, slp_n = 1'b1;
  logic [11:0] wa12, wb12;
  logic [9:0]  wa10, wb10;
  logic        slp12, slp10;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] hist = '0;
  logic [11:0] ea12 = '0, eb12 = '0;
  logic [9:0]  ea10 = '0, eb10 = '0;

  always #5 clk = ~clk;

  dual_dac_regs #(.WIDTH(12)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sck), .ser_data_i(sdat), .ser_en_ni(en_n),
    .load_a_ni(lda_n), .load_b_ni(ldb_n), .preset_ni(pre_n), .preset_mid_i(mid),
    .sleep_ni(slp_n), .word_a_o(wa12), .word_b_o(wb12), .sleep_o(slp12));

  dual_dac_regs #(.WIDTH(10)) dut10 (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sck), .ser_data_i(sdat), .ser_en_ni(en_n),
    .load_a_ni(lda_n), .load_b_ni(ldb_n), .preset_ni(pre_n), .preset_mid_i(mid),
    .sleep_ni(slp_n), .word_a_o(wa10), .word_b_o(wb10), .sleep_o(slp10));

  task automatic cmp(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input bit exp_slp);
    cmp({req, " word_a w12"}, int'(wa12), int'(ea12));
    cmp({req, " word_b w12"}, int'(wb12), int'(eb12));
    cmp({req, " word_a w10"}, int'(wa10), int'(ea10));
    cmp({req, " word_b w10"}, int'(wb10), int'(eb10));
    cmp({req, " sleep w12"}, int'(slp12), int'(exp_slp));
    cmp({req, " sleep w10"}, int'(slp10), int'(exp_slp));
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit: 3 system cycles low, 3 high
  task automatic send_bit(input bit b);
    sdat = b; sck = 1'b0; wait_n(3);
    sck = 1'b1; wait_n(3);
    if (!en_n) hist = {hist[30:0], b};
  endtask

  task automatic send_frame(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_load(input bit a, input bit b);
    if (a) lda_n = 1'b0;
    if (b) ldb_n = 1'b0;
    wait_n(4);
    lda_n = 1'b1; ldb_n = 1'b1; wait_n(4);
    if (a) begin ea12 = hist[11:0]; ea10 = hist[9:0]; end
    if (b) begin eb12 = hist[11:0]; eb10 = hist[9:0]; end
  endtask

  task automatic t_reset();
    wait_n(4);
    check_all("R12 reset", 1'b0);
  endtask

  task automatic t_frame12_a();
    en_n = 1'b0; send_frame(16'h0A5C, 12); en_n = 1'b1; wait_n(2);
    pulse_load(1'b1, 1'b0);
    cmp("R1 msb-first w12", int'(wa12), 'hA5C);
    check_all("R1 R4 load A, R5 B untouched", 1'b0);
  endtask

  task automatic t_frame10_b();
    en_n = 1'b0; send_frame(16'h02B7, 10); en_n = 1'b1; wait_n(2);
    pulse_load(1'b0, 1'b1);
    cmp("R3 10-clock w10", int'(wb10), 'h2B7);
    check_all("R5 load B, A untouched", 1'b0);
  endtask

  task automatic t_frame16_both();
    en_n = 1'b0; send_frame(16'hF3C6, 16); en_n = 1'b1; wait_n(2);
    pulse_load(1'b1, 1'b1);
    cmp("R3 16-clock w12", int'(wa12), 'h3C6);
    cmp("R3 16-clock w10", int'(wa10), 'h3C6);
    cmp("R6 both equal w12", int'(wb12), int'(wa12));
    check_all("R3 R6 both", 1'b0);
  endtask

  task automatic t_en_high();
    en_n = 1'b0; send_frame(16'h0155, 12); en_n = 1'b1;
    send_frame(16'h0FFF, 12);
    pulse_load(1'b1, 1'b0);
    cmp("R2 shift held w12", int'(wa12), 'h155);
    check_all("R2 R7 load with enable high", 1'b0);
  endtask

  task automatic t_follow();
    ldb_n = 1'b0; wait_n(4);
    en_n = 1'b0; send_frame(16'h09E1, 12); en_n = 1'b1; wait_n(4);
    eb12 = hist[11:0]; eb10 = hist[9:0];
    check_all("R4 follows while strobe low", 1'b0);
    ldb_n = 1'b1; wait_n(4);
    en_n = 1'b0; send_frame(16'h0333, 12); en_n = 1'b1; wait_n(4);
    check_all("R4 holds after strobe rise", 1'b0);
  endtask

  task automatic t_preset();
    mid = 1'b0; lda_n = 1'b0; pre_n = 1'b0; wait_n(4);
    ea12 = '0; eb12 = '0; ea10 = '0; eb10 = '0;
    check_all("R8 R10 preset zero over load", 1'b0);
    lda_n = 1'b1; wait_n(4); pre_n = 1'b1; wait_n(4);
    mid = 1'b1; wait_n(4); ldb_n = 1'b0; pre_n = 1'b0; wait_n(4);
    ea12 = 12'h800; eb12 = 12'h800; ea10 = 10'h200; eb10 = 10'h200;
    check_all("R9 R10 preset midscale", 1'b0);
    ldb_n = 1'b1; wait_n(4); pre_n = 1'b1; wait_n(4);
    check_all("R9 preset release keeps value", 1'b0);
  endtask

  task automatic t_sleep();
    slp_n = 1'b0; wait_n(4);
    check_all("R11 sleep flag, words kept", 1'b1);
    en_n = 1'b0; send_frame(16'h0C3A, 12); en_n = 1'b1;
    pulse_load(1'b0, 1'b1);
    check_all("R11 load during sleep", 1'b1);
    slp_n = 1'b1; wait_n(4);
    check_all("R11 wake keeps latest words", 1'b0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    t_reset();
    t_frame12_a();
    t_frame10_b();
    t_frame16_both();
    t_en_high();
    t_follow();
    t_preset();
    t_sleep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule